// File: doc/BRIEF.md
# Configurable Interrupt Source Conditioner

This block sits between a bank of raw interrupt lines and the rest of an interrupt controller. Every line passes through a two-flop synchronizer. It is then conditioned by its own polarity, trigger-mode and dual-edge settings into a pending bit. A level-mode source's pending bit follows the adjusted line. An edge-mode source's pending bit is an edge latch, which holds until software clears it. Each source also has an enable bit. The output vector carries the sources that are both pending and enabled, and the next stage of the controller takes it from there.

Software reaches the block through a plain 32-bit register port. The port has a word address, a write strobe, write data and combinational read data. The word address splits into a 3-bit window code in bits [6:4] and a 4-bit word index in bits [3:0]. Every configuration window packs 32 sources into a word, so source n sits at bit n mod 32 of word n/32. The enables are changed only through separate write-one-to-set and write-one-to-clear windows. A single command window sets or clears any one source's edge latch.

Window codes: 0 polarity, 1 trigger, 2 dual-edge, 3 enable-set, 4 enable-clear, 5 enable view, 6 pending view, 7 edge command.

Top module: `irq_src_cond`

## Requirements
- R1: After reset the polarity, trigger, dual-edge and enable views read 0 for every source and `irq_out` is all 0, so every source starts active-low and level-sensitive.
- R2: A level-mode source with polarity 0 is pending while its line is low and not pending while it is high. The change appears in the pending view (window 6) two clock edges after the line changes.
- R3: A level-mode source with polarity 1 is pending while its line is high.
- R4: An edge-mode source (trigger bit 1) with polarity 1 latches pending on a rising edge of its line. The bit stays pending after the line falls again.
- R5: An edge-mode source with polarity 0 latches on a falling edge and ignores a rising edge.
- R6: With its dual-edge bit set, an edge-mode source latches on either edge whatever its polarity.
- R7: Writing a word to the enable-set window (3) enables each source whose bit is 1 and leaves sources written with 0 unchanged.
- R8: Writing a word to the enable-clear window (4) disables each source whose bit is 1 and leaves sources written with 0 unchanged.
- R9: `irq_out[n]` is 1 exactly when source n is pending and enabled.
- R10: A write to the edge command window (7) acts on the source whose number is in write-data bits [5:0]. Bit 31 = 1 sets that source's edge latch and bit 31 = 0 clears it.
- R11: Source n maps to bit n mod 32 of word n/32 in every window. The enable-set, enable-clear and command windows read 0, and writes to the enable and pending views are ignored.
- R12: A source in level mode does not capture edges in its latch, so switching it to edge mode after line activity shows no stale pending bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_raw | input | NUM_SRC | Raw interrupt lines, asynchronous to clk |
| reg_addr | input | 7 | Word address: window [6:4], word index [3:0] |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq_out | output | NUM_SRC | Sources that are pending and enabled |

## Verification
The pending view exposes each source's conditioned state directly. A wrong edge latch or a bad previous-sample flop therefore shows up at the port at the third clock edge after a line transition, where the latch should have caught or ignored that transition. A corrupt enable bit shows up in `irq_out` in the same cycle as the pending bit it gates. A lost latch also shows as a pending bit that falls without a clear command. The directed tests read the views after each line change and each command, so such faults are seen within a few cycles of their cause.

// File: rtl/isc_pkg.sv
package isc_pkg;
    localparam int WORD_W    = 32;
    localparam int WIN_BITS  = 3;
    localparam int IDX_BITS  = 4;
    localparam int ADDR_W    = WIN_BITS + IDX_BITS;
    localparam int MAX_WORDS = 1 << IDX_BITS;

    typedef enum logic [WIN_BITS-1:0] {
        WIN_POL  = 3'd0,
        WIN_TRIG = 3'd1,
        WIN_DUAL = 3'd2,
        WIN_MSET = 3'd3,
        WIN_MCLR = 3'd4,
        WIN_MASK = 3'd5,
        WIN_PEND = 3'd6,
        WIN_EDGE = 3'd7
    } isc_win_e;
endpackage

// File: rtl/isc_sync.sv
module isc_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= d_async;
            stage2_q <= stage1_q;
        end
    end

    assign q_sync = stage2_q;
endmodule

// File: rtl/isc_edge_unit.sv
module isc_edge_unit (
    input  logic clk,
    input  logic rst_n,
    input  logic line_s,
    input  logic pol,
    input  logic trig,
    input  logic dual,
    input  logic cmd_set,
    input  logic cmd_clr,
    output logic pend
);
    logic prev_q;
    logic latch_q;
    logic rise;
    logic fall;
    logic hit;

    assign rise = line_s & ~prev_q;
    assign fall = ~line_s & prev_q;

    // only an edge-mode source captures transitions
    always_comb begin
        if (!trig)
            hit = 1'b0;
        else if (dual)
            hit = rise | fall;
        else
            hit = pol ? rise : fall;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q  <= 1'b0;
            latch_q <= 1'b0;
        end else begin
            prev_q  <= line_s;
            // a captured edge wins over a simultaneous clear
            latch_q <= cmd_set | hit | (latch_q & ~cmd_clr);
        end
    end

    assign pend = trig ? latch_q : ~(line_s ^ pol);
endmodule

// File: rtl/isc_cfg_regs.sv
module isc_cfg_regs
    import isc_pkg::*;
#(
    parameter int NUM_SRC = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [WORD_W-1:0]    reg_wdata,
    input  logic [NUM_SRC-1:0]   pend,
    output logic [NUM_SRC-1:0]   pol_q,
    output logic [NUM_SRC-1:0]   trig_q,
    output logic [NUM_SRC-1:0]   dual_q,
    output logic [NUM_SRC-1:0]   mask_q,
    output logic [NUM_SRC-1:0]   cmd_set,
    output logic [NUM_SRC-1:0]   cmd_clr,
    output logic [WORD_W-1:0]    reg_rdata
);
    localparam int SRC_W     = $clog2(NUM_SRC);
    localparam int NUM_WORDS = (NUM_SRC + WORD_W - 1) / WORD_W;

    isc_win_e            win;
    logic [IDX_BITS-1:0] word;
    logic                cmd_hit;

    assign win     = isc_win_e'(reg_addr[ADDR_W-1:IDX_BITS]);
    assign word    = reg_addr[IDX_BITS-1:0];
    assign cmd_hit = reg_wr && (win == WIN_EDGE);

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        localparam int W = i / WORD_W;
        localparam int B = i % WORD_W;
        logic sel_w;
        logic p_q, t_q, d_q, m_q;

        assign sel_w = reg_wr && (word == IDX_BITS'(W));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                p_q <= 1'b0;
                t_q <= 1'b0;
                d_q <= 1'b0;
                m_q <= 1'b0;
            end else begin
                if (sel_w && win == WIN_POL)  p_q <= reg_wdata[B];
                if (sel_w && win == WIN_TRIG) t_q <= reg_wdata[B];
                if (sel_w && win == WIN_DUAL) d_q <= reg_wdata[B];
                if (sel_w && win == WIN_MSET && reg_wdata[B])
                    m_q <= 1'b1;
                else if (sel_w && win == WIN_MCLR && reg_wdata[B])
                    m_q <= 1'b0;
            end
        end

        assign pol_q[i]   = p_q;
        assign trig_q[i]  = t_q;
        assign dual_q[i]  = d_q;
        assign mask_q[i]  = m_q;
        assign cmd_set[i] = cmd_hit && reg_wdata[WORD_W-1]
                            && (reg_wdata[SRC_W-1:0] == SRC_W'(i));
        assign cmd_clr[i] = cmd_hit && !reg_wdata[WORD_W-1]
                            && (reg_wdata[SRC_W-1:0] == SRC_W'(i));
    end

    function automatic logic [WORD_W-1:0] pick(input logic [NUM_SRC-1:0] v,
                                               input logic [IDX_BITS-1:0] w);
        logic [WORD_W-1:0] r;
        r = '0;
        for (int b = 0; b < WORD_W; b++) begin
            int idx;
            idx = int'(w) * WORD_W + b;
            if (idx < NUM_SRC && int'(w) < NUM_WORDS)
                r[b] = v[idx];
        end
        return r;
    endfunction

    always_comb begin
        unique case (win)
            WIN_POL:  reg_rdata = pick(pol_q, word);
            WIN_TRIG: reg_rdata = pick(trig_q, word);
            WIN_DUAL: reg_rdata = pick(dual_q, word);
            WIN_MASK: reg_rdata = pick(mask_q, word);
            WIN_PEND: reg_rdata = pick(pend, word);
            WIN_MSET, WIN_MCLR, WIN_EDGE: reg_rdata = '0;
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/irq_src_cond.sv
module irq_src_cond
    import isc_pkg::*;
#(
    parameter int NUM_SRC = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_SRC-1:0]  irq_raw,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic                reg_wr,
    input  logic [WORD_W-1:0]   reg_wdata,
    output logic [WORD_W-1:0]   reg_rdata,
    output logic [NUM_SRC-1:0]  irq_out
);
    logic [NUM_SRC-1:0] line_s;
    logic [NUM_SRC-1:0] pol_q;
    logic [NUM_SRC-1:0] trig_q;
    logic [NUM_SRC-1:0] dual_q;
    logic [NUM_SRC-1:0] mask_q;
    logic [NUM_SRC-1:0] cmd_set;
    logic [NUM_SRC-1:0] cmd_clr;
    logic [NUM_SRC-1:0] pend;

    isc_sync #(.WIDTH(NUM_SRC)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (irq_raw),
        .q_sync  (line_s)
    );

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_cond
        isc_edge_unit u_edge (
            .clk     (clk),
            .rst_n   (rst_n),
            .line_s  (line_s[i]),
            .pol     (pol_q[i]),
            .trig    (trig_q[i]),
            .dual    (dual_q[i]),
            .cmd_set (cmd_set[i]),
            .cmd_clr (cmd_clr[i]),
            .pend    (pend[i])
        );
    end

    isc_cfg_regs #(.NUM_SRC(NUM_SRC)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .pend      (pend),
        .pol_q     (pol_q),
        .trig_q    (trig_q),
        .dual_q    (dual_q),
        .mask_q    (mask_q),
        .cmd_set   (cmd_set),
        .cmd_clr   (cmd_clr),
        .reg_rdata (reg_rdata)
    );

    assign irq_out = pend & mask_q;
endmodule

// File: rtl/isc_checker.sv
module isc_checker
    import isc_pkg::*;
#(
    parameter int NUM_SRC = 64
) (
    input logic                clk,
    input logic                rst_n,
    input logic                reg_wr,
    input logic [ADDR_W-1:0]   reg_addr,
    input logic [WORD_W-1:0]   reg_wdata,
    input logic [NUM_SRC-1:0]  irq_out,
    input logic [NUM_SRC-1:0]  mask_q,
    input logic [NUM_SRC-1:0]  trig_q,
    input logic [NUM_SRC-1:0]  pend
);
    localparam int LO_W  = (NUM_SRC < WORD_W) ? NUM_SRC : WORD_W;
    localparam int SRC_W = $clog2(NUM_SRC);

    logic wr_set0, wr_clr0, wr_cmd_set0;
    assign wr_set0 = reg_wr && reg_addr == {WIN_MSET, IDX_BITS'(0)};
    assign wr_clr0 = reg_wr && reg_addr == {WIN_MCLR, IDX_BITS'(0)};
    assign wr_cmd_set0 = reg_wr && reg_addr[ADDR_W-1:IDX_BITS] == WIN_EDGE
                         && reg_wdata[WORD_W-1] && reg_wdata[SRC_W-1:0] == '0;

    AST_MSET_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set0 |=> ((mask_q[LO_W-1:0] & $past(reg_wdata[LO_W-1:0])) == $past(reg_wdata[LO_W-1:0]))); // R7

    AST_MCLR_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr0 |=> ((mask_q[LO_W-1:0] & $past(reg_wdata[LO_W-1:0])) == '0)); // R8

    AST_OUT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out & ~mask_q) == '0); // R9

    AST_CMD_SETS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmd_set0 && trig_q[0]) |=> pend[0]); // R10
endmodule

bind irq_src_cond isc_checker #(.NUM_SRC(NUM_SRC)) u_isc_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .irq_out   (irq_out),
    .mask_q    (mask_q),
    .trig_q    (trig_q),
    .pend      (pend)
);

// File: tb/test_irq_src_cond.sv
`timescale 1ns/1ps
module test_irq_src_cond;
    localparam int N = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  irq_raw = '0;
    logic [6:0]    reg_addr = '0;
    logic          reg_wr = 1'b0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [N-1:0]  irq_out;

    int n_run = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    irq_src_cond #(.NUM_SRC(N)) i_irq_src_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_raw   (irq_raw),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_out   (irq_out)
    );

    function automatic logic [6:0] adr(input int win, input int word);
        return {3'(win), 4'(word)};
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input int win, input int word, input logic [31:0] d);
        @(negedge clk);
        reg_addr = adr(win, word);
        reg_wdata = d;
        reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int win, input int word, output logic [31:0] d);
        @(negedge clk);
        reg_addr = adr(win, word);
        #1 d = reg_rdata;
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        for (int w = 0; w < 2; w++) begin
            rd(0, w, d); check("R1 pol", d, 32'h0);
            rd(1, w, d); check("R1 trig", d, 32'h0);
            rd(2, w, d); check("R1 dual", d, 32'h0);
            rd(5, w, d); check("R1 mask", d, 32'h0);
            rd(6, w, d); check("R2 low lines pending", d, 32'hFFFF_FFFF);
        end
        check("R1 irq_out lo", irq_out[31:0], 32'h0);
        check("R1 irq_out hi", irq_out[63:32], 32'h0);
    endtask

    task automatic t_level();
        logic [31:0] d;
        irq_raw[5] = 1'b1;
        settle();
        rd(6, 0, d); check("R2 high line not pending", d, 32'hFFFF_FFDF);
        wr(0, 0, 32'h0000_0020);
        rd(6, 0, d); check("R3 active-high pending", d, 32'hFFFF_FFFF);
        irq_raw[5] = 1'b0;
        settle();
        rd(6, 0, d); check("R3 low line not pending", d, 32'hFFFF_FFDF);
    endtask

    task automatic t_mask();
        logic [31:0] d;
        wr(3, 1, 32'h0000_0003);
        rd(5, 1, d); check("R7 set", d, 32'h0000_0003);
        wr(3, 1, 32'h0000_0004);
        rd(5, 1, d); check("R7 zeros keep", d, 32'h0000_0007);
        wr(4, 1, 32'h0000_0002);
        rd(5, 1, d); check("R8 clear", d, 32'h0000_0005);
        rd(5, 0, d); check("R11 other word untouched", d, 32'h0);
        rd(3, 1, d); check("R11 set window reads 0", d, 32'h0);
        rd(4, 1, d); check("R11 clr window reads 0", d, 32'h0);
        wr(5, 1, 32'hFFFF_FFFF);
        rd(5, 1, d); check("R11 view write ignored", d, 32'h0000_0005);
        wr(6, 1, 32'h0);
        rd(6, 1, d); check("R11 pend view write ignored", d, 32'hFFFF_FFFF);
    endtask

    task automatic t_out();
        check("R9 out hi", irq_out[63:32], 32'h0000_0005);
        irq_raw[34] = 1'b1;
        settle();
        check("R9 out after line high", irq_out[63:32], 32'h0000_0001);
        irq_raw[34] = 1'b0;
        settle();
        wr(4, 1, 32'h0000_0005);
    endtask

    task automatic t_edge_rise();
        logic [31:0] d;
        wr(1, 1, 32'h0000_0100);
        wr(0, 1, 32'h0000_0100);
        rd(6, 1, d); check("R4 edge idle", d[8], 1'b0);
        irq_raw[40] = 1'b1;
        settle();
        rd(6, 1, d); check("R4 rise latched", d[8], 1'b1);
        irq_raw[40] = 1'b0;
        settle();
        rd(6, 1, d); check("R4 held after fall", d[8], 1'b1);
        wr(3, 1, 32'h0000_0100);
        check("R9 latched source out", irq_out[40], 1'b1);
        wr(7, 0, 32'd40);
        rd(6, 1, d); check("R10 clear cmd", d[8], 1'b0);
        wr(7, 0, 32'h8000_0000 | 32'd40);
        rd(6, 1, d); check("R10 set cmd", d[8], 1'b1);
        wr(7, 0, 32'd40);
        wr(4, 1, 32'h0000_0100);
    endtask

    task automatic t_edge_fall();
        logic [31:0] d;
        wr(1, 1, 32'h0000_0300);
        irq_raw[41] = 1'b1;
        settle();
        rd(6, 1, d); check("R5 rise ignored", d[9], 1'b0);
        irq_raw[41] = 1'b0;
        settle();
        rd(6, 1, d); check("R5 fall latched", d[9], 1'b1);
        wr(7, 0, 32'd41);
    endtask

    task automatic t_dual();
        logic [31:0] d;
        wr(1, 1, 32'h0000_0700);
        wr(2, 1, 32'h0000_0400);
        irq_raw[42] = 1'b1;
        settle();
        rd(6, 1, d); check("R6 rise latched", d[10], 1'b1);
        wr(7, 0, 32'd42);
        rd(6, 1, d); check("R6 cleared", d[10], 1'b0);
        irq_raw[42] = 1'b0;
        settle();
        rd(6, 1, d); check("R6 fall latched", d[10], 1'b1);
    endtask

    task automatic t_no_stale();
        logic [31:0] d;
        irq_raw[3] = 1'b1;
        settle();
        irq_raw[3] = 1'b0;
        settle();
        wr(1, 0, 32'h0000_0008);
        rd(6, 0, d); check("R12 no stale latch", d[3], 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        settle();
        t_reset();
        t_level();
        t_mask();
        t_out();
        t_edge_rise();
        t_edge_fall();
        t_dual();
        t_no_stale();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule